// File: doc/BRIEF.md
# Machine-Cycle Watchdog with Power-Down Gating

This block is the watchdog of a small 8-bit controller. It counts machine-cycle ticks supplied by a tick-enable input. Once armed, it raises a device reset pulse if software fails to service it before the selected timeout. A 3-bit select field sets the timeout to one of eight power-of-two lengths. Arming and servicing use the same two-write key on a write-only service register. Only a hardware reset can disarm the watchdog. The reset pulse also disarms it.

Power modes are handled inside the block. Entry into power-down freezes the count, because the oscillator is stopped in that mode. A wake-up through a level-sensitive external interrupt keeps the count held while that line stays low. Counting resumes only after the line returns high. Idle mode does not gate the count at all. Software must leave idle periodically to service the watchdog.

Top module: `mc_watchdog`

## Requirements
- R1: With select value S, the armed watchdog overflows on exactly the (2^(BASE_EXP+S) − 1)-th counted tick after the last service. Before that tick the reset output stays low and `wdt_count` shows the number of ticks counted so far.
- R2: Writing the timeout register (`reg_sel`=1) stores data bits 2:0 as S. `rd_data` returns S in bits 2:0 and zero in bits 7:3.
- R3: A service-register write (`reg_sel`=0) of 0x1E, followed directly by a service-register write of 0xE1, arms the watchdog and clears the count to 0. A second such pair while armed clears the count again.
- R4: Any write between 0x1E and 0xE1 aborts the key, whether it goes to the service register with another value or to the timeout register. A following 0xE1 alone then has no effect.
- R5: On overflow, `wdt_reset` goes high one cycle later and stays high for exactly PULSE_LEN (96) clock cycles.
- R6: On overflow the watchdog disarms and the count returns to 0.
- R7: A `pd_enter` pulse puts the block in power-down. There the count holds its value regardless of ticks, and writes are ignored.
- R8: In power-down, a low `ext_int_n` moves the block to a held state in which the count still holds. The next cycle with `ext_int_n` high returns it to counting.
- R9: `idle_mode` has no effect: ticks are counted while it is high.
- R10: Asynchronous reset (`rst_n` low) disarms the watchdog, clears the count and S, and leaves power-down.
- R11: The count advances only in cycles where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| tick_en | input | 1 | One-cycle strobe marking a machine cycle |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the service register, 1 selects the timeout register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Timeout register readback |
| pd_enter | input | 1 | Pulse marking entry into power-down |
| ext_int_n | input | 1 | Level-sensitive external interrupt line, active low |
| idle_mode | input | 1 | High while the CPU is idle |
| wdt_armed | output | 1 | Watchdog is armed and counting |
| wdt_count | output | BASE_EXP+2^SEL_W−1 | Current tick count |
| wdt_reset | output | 1 | Device reset pulse |

## Verification
The hardest situation to reach is the interrupt wake-up hold. The watchdog must already be armed and part-way through its count. Power-down is then entered, and the interrupt line is dropped and raised while ticks keep arriving. The bench arms the counter, advances it to a known value, and pulses `pd_enter`. It then drives ticks continuously through the frozen state and the held state. Once the line goes high it confirms that counting resumes from the preserved value. The bench shortens BASE_EXP so that overflow at two select values, and the full 96-cycle pulse, fit in a short run.

// File: rtl/mc_wdt_pkg.sv
package mc_wdt_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h1E;
  localparam logic [7:0] KEY_CLOSE = 8'hE1;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_DOWN = 2'd1,
    PWR_HOLD = 2'd2
  } pwr_state_t;

  typedef enum logic {
    KEY_WAIT = 1'b0,
    KEY_HALF = 1'b1
  } key_state_t;
endpackage

// File: rtl/mc_wdt_keyseq.sv
module mc_wdt_keyseq
  import mc_wdt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              svc_fire
);
  key_state_t st_q, st_d;
  logic       close_hit;

  assign close_hit = wr_ok && !reg_sel && (wr_data[7:0] == KEY_CLOSE);

  always_comb begin
    st_d     = st_q;
    svc_fire = 1'b0;
    if (wr_ok) begin
      if (st_q == KEY_HALF && close_hit) begin
        svc_fire = 1'b1;
        st_d     = KEY_WAIT;
      end else if (!reg_sel && wr_data[7:0] == KEY_OPEN) begin
        st_d = KEY_HALF;
      end else begin
        st_d = KEY_WAIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KEY_WAIT;
    else        st_q <= st_d;
  end

  // R4: the key fires only straight after a first-key write
  assert_key_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fire |-> $past(wr_ok) || st_q == KEY_HALF);
endmodule

// File: rtl/mc_wdt_pwrgate.sv
module mc_wdt_pwrgate
  import mc_wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pd_enter,
  input  logic ext_int_n,
  output logic run_ok
);
  pwr_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PWR_RUN:  if (pd_enter)   st_d = PWR_DOWN;
      PWR_DOWN: if (!ext_int_n) st_d = PWR_HOLD;
      PWR_HOLD: if (ext_int_n)  st_d = PWR_RUN;
      default:                  st_d = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PWR_RUN;
    else        st_q <= st_d;
  end

  assign run_ok = (st_q == PWR_RUN);

  // R8: held state persists while the interrupt line stays low
  assert_hold_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PWR_HOLD && !ext_int_n) |=> st_q == PWR_HOLD);
  // R7: power-down persists while the interrupt line stays high
  assert_down_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PWR_DOWN && ext_int_n) |=> !run_ok);
endmodule

// File: rtl/mc_wdt_counter.sv
module mc_wdt_counter #(
  parameter int BASE_EXP = 14,
  parameter int SEL_W    = 3,
  localparam int CNT_W   = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run_ok,
  input  logic             svc_fire,
  input  logic [SEL_W-1:0] sel,
  output logic             armed,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic [CNT_W:0]   lim;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] cnt_d;
  logic             arm_d;
  logic             step;

  assign lim    = ({{CNT_W{1'b0}}, 1'b1} << (BASE_EXP + int'(sel))) - 1'b1;
  assign last_q = CNT_W'(lim - 1'b1);
  assign step   = armed && run_ok && tick_en;
  assign ovf    = !svc_fire && step && (count == last_q);

  always_comb begin
    cnt_d = count;
    arm_d = armed;
    if (svc_fire) begin
      cnt_d = '0;
      arm_d = 1'b1;
    end else if (ovf) begin
      cnt_d = '0;
      arm_d = 1'b0;
    end else if (step) begin
      cnt_d = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else begin
      count <= cnt_d;
      armed <= arm_d;
    end
  end

  // R7: frozen while power gating holds the counter
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_ok && !svc_fire) |=> $stable(count));
  // R6: overflow disarms and clears
  assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (!armed && count == '0));
  // R11: no tick, no advance
  assert_tick_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !svc_fire) |=> $stable(count));
endmodule

// File: rtl/mc_wdt_pulse.sv
module mc_wdt_pulse #(
  parameter int PULSE_LEN = 96,
  localparam int PW = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_out
);
  logic [PW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (fire)              left_d = PW'(PULSE_LEN);
    else if (left_q != '0) left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign rst_out = (left_q != '0);

  // R5: overflow starts the pulse on the next cycle
  assert_pulse_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rst_out);
  // R5: no pulse appears without an overflow
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out && !fire) |=> !rst_out);
endmodule

// File: rtl/mc_watchdog.sv
module mc_watchdog
  import mc_wdt_pkg::*;
#(
  parameter int BASE_EXP  = 14,
  parameter int SEL_W     = 3,
  parameter int PULSE_LEN = 96,
  parameter int DATA_W    = 8,
  localparam int CNT_W    = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pd_enter,
  input  logic              ext_int_n,
  input  logic              idle_mode,
  output logic              wdt_armed,
  output logic [CNT_W-1:0]  wdt_count,
  output logic              wdt_reset
);
  logic             run_ok;
  logic             wr_ok;
  logic             svc_fire;
  logic             ovf;
  logic [SEL_W-1:0] sel_q, sel_d;

  assign wr_ok = wr_en && run_ok;

  always_comb begin
    sel_d = sel_q;
    if (wr_ok && reg_sel) sel_d = wr_data[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign rd_data = {{(DATA_W-SEL_W){1'b0}}, sel_q};

  mc_wdt_pwrgate u_pwr (
    .clk(clk), .rst_n(rst_n), .pd_enter(pd_enter),
    .ext_int_n(ext_int_n), .run_ok(run_ok)
  );

  mc_wdt_keyseq #(.DATA_W(DATA_W)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .reg_sel(reg_sel),
    .wr_data(wr_data), .svc_fire(svc_fire)
  );

  mc_wdt_counter #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_ok(run_ok),
    .svc_fire(svc_fire), .sel(sel_q), .armed(wdt_armed),
    .count(wdt_count), .ovf(ovf)
  );

  mc_wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(ovf), .rst_out(wdt_reset)
  );

  // R3: a completed key arms and clears
  assert_service_R3: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fire |=> (wdt_armed && wdt_count == '0));
  // R9: idle does not stop counting
  assert_idle_counts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_mode && run_ok && wdt_armed && tick_en && !svc_fire && !ovf)
      |=> wdt_count == $past(wdt_count) + 1'b1);
  // R2: reserved read bits are zero
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:SEL_W] == '0);
endmodule

// File: tb/mc_watchdog_test.sv
module mc_watchdog_test;
  localparam int BE = 4;
  localparam int CW = BE + 7;

  logic          clk = 1'b0;
  logic          rst_n, tick_en, wr_en, reg_sel, pd_enter, ext_int_n, idle_mode;
  logic [7:0]    wr_data, rd_data;
  logic          wdt_armed, wdt_reset;
  logic [CW-1:0] wdt_count;
  int            n_chk = 0, n_err = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  mc_watchdog #(.BASE_EXP(BE)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
    .pd_enter(pd_enter), .ext_int_n(ext_int_n), .idle_mode(idle_mode),
    .wdt_armed(wdt_armed), .wdt_count(wdt_count), .wdt_reset(wdt_reset)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; reg_sel = 1'b0;
    wr_data = '0; pd_enter = 1'b0; ext_int_n = 1'b1; idle_mode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic arm();
    wr(1'b0, 8'h1E);
    wr(1'b0, 8'hE1);
  endtask

  task automatic ticks(int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pulse_len(string req);
    int hi = 0;
    while (wdt_reset && hi < 1000) begin
      hi++;
      @(negedge clk);
    end
    chk(req, hi, 96);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R10 reset", wdt_reset, 0);
    chk("R10 armed", wdt_armed, 0);
    chk("R10 count", wdt_count, 0);
    chk("R10 sel", rd_data, 0);
  endtask

  task automatic t_select();
    wr(1'b1, 8'hFD);
    chk("R2 readback", rd_data, 5);
    wr(1'b1, 8'h00);
    chk("R2 readback zero", rd_data, 0);
  endtask

  task automatic t_key();
    wr(1'b0, 8'h1E); wr(1'b0, 8'h55); wr(1'b0, 8'hE1);
    chk("R4 abort by value", wdt_armed, 0);
    wr(1'b0, 8'h1E); wr(1'b1, 8'h02); wr(1'b0, 8'hE1);
    chk("R4 abort by select write", wdt_armed, 0);
    chk("R2 sel via abort", rd_data, 2);
    wr(1'b1, 8'h00);
    arm();
    chk("R3 armed", wdt_armed, 1);
    chk("R3 count zero", wdt_count, 0);
  endtask

  task automatic t_overflow_s0();
    ticks(14);
    chk("R1 count 14", wdt_count, 14);
    chk("R1 no reset early", wdt_reset, 0);
    ticks(1);
    chk("R5 reset starts", wdt_reset, 1);
    chk("R6 disarmed", wdt_armed, 0);
    chk("R6 count cleared", wdt_count, 0);
    pulse_len("R5 pulse length");
  endtask

  task automatic t_overflow_s1();
    wr(1'b1, 8'h01);
    arm();
    ticks(30);
    chk("R1 S=1 count 30", wdt_count, 30);
    chk("R1 S=1 no reset", wdt_reset, 0);
    ticks(1);
    chk("R1 S=1 overflow", wdt_reset, 1);
    pulse_len("R5 pulse length S=1");
    wr(1'b1, 8'h00);
  endtask

  task automatic t_service_restart();
    arm();
    ticks(10);
    arm();
    chk("R3 reservice clears", wdt_count, 0);
    ticks(14);
    chk("R3 no early reset", wdt_reset, 0);
    ticks(1);
    chk("R3 overflow after restart", wdt_reset, 1);
    pulse_len("R5 pulse after restart");
  endtask

  task automatic t_tick_gate();
    arm();
    ticks(3);
    repeat (10) @(negedge clk);
    chk("R11 no tick no count", wdt_count, 3);
    tick_en = 1'b1; @(negedge clk); tick_en = 1'b0; @(negedge clk);
    tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
    chk("R11 sparse ticks", wdt_count, 5);
  endtask

  task automatic t_power_down();
    @(negedge clk);
    pd_enter = 1'b1;
    @(negedge clk);
    pd_enter = 1'b0;
    ticks(40);
    chk("R7 frozen in power-down", wdt_count, 5);
    wr(1'b1, 8'h07);
    chk("R7 write ignored", rd_data, 0);
    ext_int_n = 1'b0;
    ticks(40);
    chk("R8 held while line low", wdt_count, 5);
    chk("R8 no reset while held", wdt_reset, 0);
    @(negedge clk);
    ext_int_n = 1'b1;
    @(negedge clk);
    ticks(3);
    chk("R8 resumes after release", wdt_count, 8);
  endtask

  task automatic t_idle();
    idle_mode = 1'b1;
    arm();
    ticks(7);
    chk("R9 counts in idle", wdt_count, 7);
    idle_mode = 1'b0;
  endtask

  task automatic t_reset_midrun();
    wr(1'b1, 8'h03);
    @(negedge clk);
    pd_enter = 1'b1;
    @(negedge clk);
    pd_enter = 1'b0;
    do_reset();
    chk("R10 disarmed", wdt_armed, 0);
    chk("R10 sel cleared", rd_data, 0);
    arm();
    ticks(2);
    chk("R10 left power-down", wdt_count, 2);
  endtask

  initial begin
    t_reset_state();
    t_select();
    t_key();
    t_overflow_s0();
    t_overflow_s1();
    t_service_restart();
    t_tick_gate();
    t_power_down();
    t_idle();
    t_reset_midrun();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule